// File: doc/BRIEF.md
# Serial Port Transfer Cycle Decoder

This block sits beside the control logic of a dual-ported video memory. It watches the memory's active-low strobes on a synchronous sampling clock. When the row strobe falls with the transfer strobe low and the column strobe still high, it classifies the cycle from the write-enable, serial-enable and function-select levels. The five classes are:

- a conventional read transfer
- a conventional write transfer
- a split read transfer
- a split write transfer
- a pseudo write transfer

The row address is captured on the row strobe fall. The column address that follows on the falling column strobe is captured as the starting tap of the serial register.

The decoder keeps three pieces of state: the current direction of the serial port, whether a conventional read has happened, and whether a pseudo write has happened since the last read. It uses this state to refuse transfers that arrive out of order. A data-moving transfer produces a single-cycle command carrying the row, the tap, the direction and a split flag. A pseudo write moves no data. It only turns the serial port around to input and sets the tap. An out-of-order split or write transfer raises an error flag that stays set until reset, and that transfer issues no command.

The strobe inputs are assumed to be already synchronous to the sampling clock.

Top module: `vxfer_decoder`

## Requirements
- R1: After reset, `ser_input_mode`, `cmd_valid` and `seq_err` are all 0.
- R2: A read transfer is decoded when, at a row strobe fall, `xfer_n`=0, `col_n`=1, `wr_n`=1 and `func_sel`=0. At the next column strobe fall it pulses `cmd_valid` with `cmd_to_serial`=1, `cmd_split`=0 and `cmd_row` holding the address seen at the row fall. It also returns the serial port to output mode.
- R3: A pseudo write is decoded when, at a row strobe fall, `xfer_n`=0, `col_n`=1, `wr_n`=0, `ser_n`=1 and `func_sel`=0. It produces no command pulse. At its column strobe fall it sets `ser_input_mode`=1.
- R4: A write transfer uses the same levels as a pseudo write but with `ser_n`=0. It pulses a command with `cmd_to_serial`=0 and `cmd_split`=0. With `STRICT_WRITE`=1, a write transfer decoded while the serial port is in output mode sets `seq_err` and issues no command.
- R5: A split read is decoded with `wr_n`=1 and `func_sel`=1. It is legal only after a conventional read transfer since reset. If legal, it pulses a command with `cmd_to_serial`=1 and `cmd_split`=1. Otherwise it sets `seq_err` and issues no command.
- R6: A split write is decoded with `wr_n`=0 and `func_sel`=1. It is legal only if a pseudo write has occurred after the most recent read transfer of either kind. If legal, it pulses a command with `cmd_to_serial`=0 and `cmd_split`=1. Otherwise it sets `seq_err` and issues no command.
- R7: In every accepted transfer, including a pseudo write, `cmd_tap` takes the low `COL_W` bits of `addr` sampled on the column strobe fall.
- R8: `cmd_valid` is high for exactly one clock per accepted data-moving transfer, on the clock after the column strobe fall is sampled.
- R9: Once set, `seq_err` stays at 1 until reset, whatever cycles follow.
- R10: A row strobe fall with `xfer_n`=1, or with `col_n` already low, is not a transfer. It changes no output.
- R11: If the row strobe rises before the column strobe falls, a decoded transfer is abandoned. No command is issued and the direction does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_n | input | 1 | Row strobe, active low |
| col_n | input | 1 | Column strobe, active low |
| xfer_n | input | 1 | Transfer select, active low |
| wr_n | input | 1 | Write enable, active low |
| ser_n | input | 1 | Serial enable, active low |
| func_sel | input | 1 | Function select; 1 selects split transfers |
| addr | input | ADDR_W | Multiplexed row/column address |
| cmd_valid | output | 1 | One-cycle transfer command pulse |
| cmd_to_serial | output | 1 | 1 = array to serial register, 0 = serial register to array |
| cmd_split | output | 1 | Command is a split (half-register) transfer |
| cmd_row | output | ROW_W | Row address of the accepted transfer |
| cmd_tap | output | COL_W | Serial tap start from the column address |
| ser_input_mode | output | 1 | Serial port direction, 1 = input |
| seq_err | output | 1 | Sticky sequencing error |

## Verification
The bench builds the decoder with its defaults: 9-bit row and column addresses and strict write checking. With these values, a write transfer attempted in output mode is treated as an error, so the bench can exercise the turnaround rule. The full 9-bit tap range is also reachable with patterns whose high bit differs between the row and column phases. The bench resets between ordering scenarios so that each refusal starts from a known state, and it compares every output against a behavioural model on each clock.

// File: rtl/vxfer_pkg.sv
package vxfer_pkg;
   typedef enum logic [2:0] {
      XK_NONE   = 3'd0,
      XK_READ   = 3'd1,
      XK_SREAD  = 3'd2,
      XK_WRITE  = 3'd3,
      XK_SWRITE = 3'd4,
      XK_PSEUDO = 3'd5
   } xfer_kind_t;
endpackage

// File: rtl/vxfer_edges.sv
module vxfer_edges #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl_n,
   output logic [N-1:0] fall,
   output logic [N-1:0] rise
);
   if (N < 1) begin : g_bad_n
      $error("vxfer_edges: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic prev_q;
      always_ff @(posedge clk) begin
         if (!rst_n) prev_q <= 1'b1;
         else        prev_q <= lvl_n[i];
      end
      assign fall[i] = prev_q & ~lvl_n[i];
      assign rise[i] = ~prev_q & lvl_n[i];
   end
endmodule

// File: rtl/vxfer_classify.sv
module vxfer_classify
   import vxfer_pkg::*;
(
   input  logic       col_n,
   input  logic       xfer_n,
   input  logic       wr_n,
   input  logic       ser_n,
   input  logic       func_sel,
   output xfer_kind_t kind
);
   always_comb begin
      kind = XK_NONE;
      if (!xfer_n && col_n) begin
         if (wr_n)          kind = func_sel ? XK_SREAD : XK_READ;
         else if (func_sel) kind = XK_SWRITE;
         else               kind = ser_n ? XK_PSEUDO : XK_WRITE;
      end
   end
endmodule

// File: rtl/vxfer_sequencer.sv
module vxfer_sequencer
   import vxfer_pkg::*;
#(
   parameter int ROW_W        = 9,
   parameter int COL_W        = 9,
   parameter bit STRICT_WRITE = 1'b1,
   parameter int ADDR_W       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              row_fall,
   input  logic              row_rise,
   input  logic              col_fall,
   input  xfer_kind_t        kind,
   input  logic [ADDR_W-1:0] addr,
   output logic              cmd_valid,
   output logic              cmd_to_serial,
   output logic              cmd_split,
   output logic [ROW_W-1:0]  cmd_row,
   output logic [COL_W-1:0]  cmd_tap,
   output logic              ser_input_mode,
   output logic              seq_err
);
   xfer_kind_t pend_q;
   logic       read_seen_q;
   logic       pseudo_seen_q;
   logic       write_ok;
   logic       legal;

   if (STRICT_WRITE) begin : g_strict
      assign write_ok = ser_input_mode;
   end else begin : g_loose
      assign write_ok = 1'b1;
   end

   always_comb begin
      case (kind)
         XK_SREAD:  legal = read_seen_q;
         XK_SWRITE: legal = pseudo_seen_q;
         XK_WRITE:  legal = write_ok;
         default:   legal = 1'b1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q         <= XK_NONE;
         read_seen_q    <= 1'b0;
         pseudo_seen_q  <= 1'b0;
         cmd_valid      <= 1'b0;
         cmd_to_serial  <= 1'b0;
         cmd_split      <= 1'b0;
         cmd_row        <= '0;
         cmd_tap        <= '0;
         ser_input_mode <= 1'b0;
         seq_err        <= 1'b0;
      end else begin
         cmd_valid <= 1'b0;
         if (row_rise) begin
            pend_q <= XK_NONE;
         end else if (row_fall) begin
            if (kind != XK_NONE) begin
               if (legal) begin
                  pend_q  <= kind;
                  cmd_row <= addr[ROW_W-1:0];
               end else begin
                  pend_q  <= XK_NONE;
                  seq_err <= 1'b1;
               end
            end
         end else if (col_fall && pend_q != XK_NONE) begin
            pend_q        <= XK_NONE;
            cmd_tap       <= addr[COL_W-1:0];
            cmd_valid     <= (pend_q != XK_PSEUDO);
            cmd_to_serial <= (pend_q == XK_READ) || (pend_q == XK_SREAD);
            cmd_split     <= (pend_q == XK_SREAD) || (pend_q == XK_SWRITE);
            case (pend_q)
               XK_READ: begin
                  ser_input_mode <= 1'b0;
                  read_seen_q    <= 1'b1;
                  pseudo_seen_q  <= 1'b0;
               end
               XK_SREAD: begin
                  ser_input_mode <= 1'b0;
                  pseudo_seen_q  <= 1'b0;
               end
               XK_PSEUDO: begin
                  ser_input_mode <= 1'b1;
                  pseudo_seen_q  <= 1'b1;
               end
               XK_WRITE: ser_input_mode <= 1'b1;
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/vxfer_decoder.sv
module vxfer_decoder
   import vxfer_pkg::*;
#(
   parameter int ROW_W        = 9,
   parameter int COL_W        = 9,
   parameter bit STRICT_WRITE = 1'b1,
   localparam int ADDR_W      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              row_n,
   input  logic              col_n,
   input  logic              xfer_n,
   input  logic              wr_n,
   input  logic              ser_n,
   input  logic              func_sel,
   input  logic [ADDR_W-1:0] addr,
   output logic              cmd_valid,
   output logic              cmd_to_serial,
   output logic              cmd_split,
   output logic [ROW_W-1:0]  cmd_row,
   output logic [COL_W-1:0]  cmd_tap,
   output logic              ser_input_mode,
   output logic              seq_err
);
   localparam int NSTROBE = 2;

   if (ROW_W < 2 || ROW_W > 16) begin : g_bad_row
      $error("vxfer_decoder: ROW_W out of range 2..16");
   end
   if (COL_W < 2 || COL_W > 16) begin : g_bad_col
      $error("vxfer_decoder: COL_W out of range 2..16");
   end

   logic [NSTROBE-1:0] fall;
   logic [NSTROBE-1:0] rise;
   xfer_kind_t         kind;

   vxfer_edges #(.N(NSTROBE)) u_edges (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_n ({col_n, row_n}),
      .fall  (fall),
      .rise  (rise)
   );

   vxfer_classify u_class (
      .col_n    (col_n),
      .xfer_n   (xfer_n),
      .wr_n     (wr_n),
      .ser_n    (ser_n),
      .func_sel (func_sel),
      .kind     (kind)
   );

   vxfer_sequencer #(
      .ROW_W        (ROW_W),
      .COL_W        (COL_W),
      .STRICT_WRITE (STRICT_WRITE),
      .ADDR_W       (ADDR_W)
   ) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .row_fall       (fall[0]),
      .row_rise       (rise[0]),
      .col_fall       (fall[1]),
      .kind           (kind),
      .addr           (addr),
      .cmd_valid      (cmd_valid),
      .cmd_to_serial  (cmd_to_serial),
      .cmd_split      (cmd_split),
      .cmd_row        (cmd_row),
      .cmd_tap        (cmd_tap),
      .ser_input_mode (ser_input_mode),
      .seq_err        (seq_err)
   );
endmodule

// File: rtl/vxfer_checks.sv
module vxfer_checks #(
   parameter int COL_W  = 9,
   parameter int ADDR_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              cmd_valid,
   input logic              cmd_to_serial,
   input logic [COL_W-1:0]  cmd_tap,
   input logic              ser_input_mode,
   input logic              seq_err
);
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err |=> seq_err);

   a_r2_read_leaves_output: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_to_serial) |-> !ser_input_mode);

   a_r4_write_in_input: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_to_serial) |-> ser_input_mode);

   a_r7_tap_from_bus: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (cmd_tap == $past(addr[COL_W-1:0])));
endmodule

bind vxfer_decoder vxfer_checks #(.COL_W(COL_W), .ADDR_W(ADDR_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .addr           (addr),
   .cmd_valid      (cmd_valid),
   .cmd_to_serial  (cmd_to_serial),
   .cmd_tap        (cmd_tap),
   .ser_input_mode (ser_input_mode),
   .seq_err        (seq_err)
);

// File: tb/vxfer_decoder_test.sv
`timescale 1ns/1ps
module vxfer_decoder_test;
   localparam int RW = 9;
   localparam int CW = 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic row_n = 1'b1, col_n = 1'b1, xfer_n = 1'b1, wr_n = 1'b1, ser_n = 1'b1, func_sel = 1'b0;
   logic [8:0] addr = '0;
   logic cmd_valid, cmd_to_serial, cmd_split, ser_input_mode, seq_err;
   logic [RW-1:0] cmd_row;
   logic [CW-1:0] cmd_tap;

   int checks = 0;
   int fails = 0;
   int pulses = 0;

   always #2 clk = ~clk;

   vxfer_decoder #(.ROW_W(RW), .COL_W(CW), .STRICT_WRITE(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .row_n(row_n), .col_n(col_n), .xfer_n(xfer_n),
      .wr_n(wr_n), .ser_n(ser_n), .func_sel(func_sel), .addr(addr),
      .cmd_valid(cmd_valid), .cmd_to_serial(cmd_to_serial), .cmd_split(cmd_split),
      .cmd_row(cmd_row), .cmd_tap(cmd_tap), .ser_input_mode(ser_input_mode),
      .seq_err(seq_err)
   );

   // Behavioural reference: kinds 0 none, 1 read, 2 split read, 3 write, 4 split write, 5 pseudo
   int m_pend, m_row, m_tap;
   bit m_valid, m_toser, m_split, m_mode, m_err, m_rd, m_pw, p_row, p_col;

   function automatic int decode(bit c, bit x, bit w, bit s, bit f);
      if (x || !c) return 0;
      if (w) return f ? 2 : 1;
      if (f) return 4;
      return s ? 5 : 3;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pend = 0; m_row = 0; m_tap = 0; m_valid = 0; m_toser = 0; m_split = 0;
         m_mode = 0; m_err = 0; m_rd = 0; m_pw = 0; p_row = 1; p_col = 1;
      end else begin
         int k;
         bit ok;
         m_valid = 0;
         if (!p_row && row_n) m_pend = 0;
         else if (p_row && !row_n) begin
            k = decode(col_n, xfer_n, wr_n, ser_n, func_sel);
            ok = (k == 2) ? m_rd : (k == 4) ? m_pw : (k == 3) ? m_mode : 1'b1;
            if (k != 0) begin
               if (ok) begin m_pend = k; m_row = int'(addr); end
               else begin m_pend = 0; m_err = 1; end
            end
         end else if (p_col && !col_n && m_pend != 0) begin
            m_tap = int'(addr);
            m_valid = (m_pend != 5);
            m_toser = (m_pend == 1 || m_pend == 2);
            m_split = (m_pend == 2 || m_pend == 4);
            if (m_pend == 1) begin m_mode = 0; m_rd = 1; m_pw = 0; end
            if (m_pend == 2) begin m_mode = 0; m_pw = 0; end
            if (m_pend == 5) begin m_mode = 1; m_pw = 1; end
            if (m_pend == 3) m_mode = 1;
            m_pend = 0;
         end
         p_row = row_n; p_col = col_n;
      end
   end

   task automatic chk(string tag, int got, int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R8 cmd_valid", int'(cmd_valid), int'(m_valid));
         chk("R2 cmd_to_serial", int'(cmd_to_serial), int'(m_toser));
         chk("R5 cmd_split", int'(cmd_split), int'(m_split));
         chk("R2 cmd_row", int'(cmd_row), m_row);
         chk("R7 cmd_tap", int'(cmd_tap), m_tap);
         chk("R3 ser_input_mode", int'(ser_input_mode), int'(m_mode));
         chk("R9 seq_err", int'(seq_err), int'(m_err));
         if (cmd_valid) pulses++;
      end
   end

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // x: transfer strobe low; early_col: column strobe low before row fall; abort: row rises before column falls
   task automatic cyc(bit x, bit w, bit s, bit f, int row, int col, bit early_col, bit abort);
      @(negedge clk);
      xfer_n = ~x; wr_n = w; ser_n = s; func_sel = f; addr = row[8:0];
      if (early_col) col_n = 1'b0;
      @(negedge clk); row_n = 1'b0;
      @(negedge clk); addr = col[8:0];
      if (abort) row_n = 1'b1;
      @(negedge clk);
      if (!abort) col_n = 1'b0;
      repeat (2) @(negedge clk);
      row_n = 1'b1; col_n = 1'b1; xfer_n = 1'b1; wr_n = 1'b1; ser_n = 1'b1; func_sel = 1'b0;
      @(negedge clk); #1;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      int p0;
      do_reset();
      @(negedge clk); #1;
      chk("R1 reset mode", int'(ser_input_mode), 0);
      chk("R1 reset valid", int'(cmd_valid), 0);
      chk("R1 reset err", int'(seq_err), 0);

      // R2, R7: conventional read
      p0 = pulses;
      cyc(1, 1, 0, 0, 'h1A5, 'h133, 0, 0);
      chk("R2 read pulse count", pulses - p0, 1);
      chk("R2 read row", int'(cmd_row), 'h1A5);
      chk("R7 read tap", int'(cmd_tap), 'h133);
      chk("R2 read direction", int'(cmd_to_serial), 1);

      // R4: write while in output mode is refused
      p0 = pulses;
      cyc(1, 0, 0, 0, 'h011, 'h022, 0, 0);
      chk("R4 strict write err", int'(seq_err), 1);
      chk("R4 strict write no pulse", pulses - p0, 0);
      // R9: error stays through a later legal read
      cyc(1, 1, 0, 0, 'h005, 'h006, 0, 0);
      chk("R9 err persists", int'(seq_err), 1);
      do_reset();
      @(negedge clk); #1;
      chk("R9 err cleared by reset", int'(seq_err), 0);

      // R3, R4, R6: read, pseudo, write, split write, split read
      cyc(1, 1, 0, 0, 'h0F0, 'h00F, 0, 0);
      p0 = pulses;
      cyc(1, 0, 1, 0, 'h123, 'h0AA, 0, 0);
      chk("R3 pseudo no pulse", pulses - p0, 0);
      chk("R3 pseudo input mode", int'(ser_input_mode), 1);
      chk("R7 pseudo sets tap", int'(cmd_tap), 'h0AA);
      p0 = pulses;
      cyc(1, 0, 0, 0, 'h077, 'h1FF, 0, 0);
      chk("R4 write pulse", pulses - p0, 1);
      chk("R4 write direction", int'(cmd_to_serial), 0);
      p0 = pulses;
      cyc(1, 0, 0, 1, 'h155, 'h100, 0, 0);
      chk("R6 split write pulse", pulses - p0, 1);
      chk("R6 split flag", int'(cmd_split), 1);
      chk("R6 no err", int'(seq_err), 0);
      p0 = pulses;
      cyc(1, 1, 0, 1, 'h0AB, 'h0CD, 0, 0);
      chk("R5 split read after read", pulses - p0, 1);
      chk("R5 split read direction", int'(cmd_to_serial), 1);
      // R6: split read cleared pseudo history
      cyc(1, 0, 0, 1, 'h001, 'h002, 0, 0);
      chk("R6 split write after read err", int'(seq_err), 1);

      // R5: split read with no prior read
      do_reset();
      p0 = pulses;
      cyc(1, 1, 0, 1, 'h040, 'h041, 0, 0);
      chk("R5 split read refused", int'(seq_err), 1);
      chk("R5 split read no pulse", pulses - p0, 0);

      // R6: split write with no pseudo write
      do_reset();
      cyc(1, 1, 0, 0, 'h010, 'h020, 0, 0);
      cyc(1, 0, 0, 1, 'h030, 'h040, 0, 0);
      chk("R6 split write refused", int'(seq_err), 1);

      // R10: non-transfer row cycles
      do_reset();
      p0 = pulses;
      cyc(0, 0, 1, 0, 'h111, 'h122, 0, 0);
      cyc(1, 0, 1, 0, 'h133, 'h144, 1, 0);
      chk("R10 no pulse", pulses - p0, 0);
      chk("R10 mode unchanged", int'(ser_input_mode), 0);
      chk("R10 tap unchanged", int'(cmd_tap), 0);

      // R11: abandoned pseudo write and read
      cyc(1, 0, 1, 0, 'h0EE, 'h0DD, 0, 1);
      chk("R11 abandoned pseudo mode", int'(ser_input_mode), 0);
      p0 = pulses;
      cyc(1, 1, 0, 0, 'h0EE, 'h0DD, 0, 1);
      chk("R11 abandoned read no pulse", pulses - p0, 0);
      chk("R11 no err", int'(seq_err), 0);

      repeat (3) @(negedge clk);
      summary();
   end
endmodule